// File: doc/BRIEF.md
# Multiplexed Eight-Digit LED Scan Controller

This block drives up to eight common-cathode seven-segment digits, or an 8x8 array of 64 single LEDs, from a register file that a host loads over a slow four-wire serial link. The link has data, clock and load inputs, plus a data output that lets several controllers share one chain. The serial lines are oversampled in the system clock domain. A 16-bit frame is shifted in and is committed on the rising edge of load.

A free-running scan sequencer gives each enabled digit a fixed slot and drives that digit's cathode low. Each slot is split into sixteen equal phases, and the sixteen-step intensity setting gates the segment lines for a matching number of those phases. A digit shows either its raw segment bits or a glyph from a small numeric font, chosen per digit. Display test and shutdown override the normal picture without changing the stored registers.

Top module: `led_scan_ctrl`

## Requirements
- R1: Serial bits are taken most significant first on each rising edge of `ser_clk`. On a rising edge of `ser_load`, the last 16 bits form a frame: bits [11:8] are the register address and bits [7:0] the data. Bits [15:12] have no effect.
- R2: `ser_dout` presents the bit that left the top of the 16-bit shift register, i.e. the bit shifted in 16 serial clocks earlier. After reset it is 0.
- R3: Register map: address 0 does nothing. Addresses 1..8 hold the data of digits 0..7. Address 9 is the decode mask, one bit per digit with bit d for digit d. Address A is intensity (bits [3:0]). Address B is the scan limit (bits [2:0]). Address C bit 0 is the run bit. Address F bit 0 is display test. Addresses D and E have no effect.
- R4: A digit with its decode bit set shows the glyph for data bits [3:0]. Codes 0..9 are the digits, then A=minus, B=E, C=H, D=L, E=P and F=blank. Segment encoding on `seg[6:0]` is a..g, with `a` on bit 6 and `g` on bit 0.
- R5: A digit with its decode bit clear drives its data byte straight onto `seg[7:0]`.
- R6: `seg[7]` is the decimal point and follows data bit 7 in both decode and raw mode.
- R7: With intensity I, the segments of a lit digit are on for I of the 16 phases of its slot. I=0 gives a dark display.
- R8: A slot lasts 16*SUB_CYCLES clocks. With scan limit N, only digits 0..N are selected, each for one slot per period of (N+1) slots. Segments are driven only while a cathode is selected.
- R9: `cath_n` is active low, and at most one of its bits is low at any time.
- R10: With the run bit clear, all cathodes stay high and `seg` is 0. Setting the run bit again restores the stored picture.
- R11: With display test set, every scanned digit shows all eight segments for the whole slot, whatever the intensity and run bit. Clearing test restores the stored picture.
- R12: Reset clears every register: digits 0, decode mask 0, intensity 0, scan limit 0, run 0 and test 0. It also sets `cath_n` to all ones and `seg` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial data in |
| ser_clk | input | 1 | Serial shift clock, sampled in the `clk` domain |
| ser_load | input | 1 | Frame commit strobe, rising edge active |
| ser_dout | output | 1 | Serial data out for chaining |
| cath_n | output | 8 | Digit cathode selects, active low |
| seg | output | 8 | Segment lines: bit 7 decimal point, bits 6..0 a..g |

## Verification
The bench sweeps all sixteen intensities, all eight scan limits and all sixteen font codes. It measures lit cycles, on cycles and the observed pattern per digit over exactly two scan periods. A wrong phase comparison would show up as an off-by-one duty, and a wrong wrap of the digit counter would light digits beyond the limit or give uneven slot counts. It also writes through frames with a nonzero upper nibble and through the dead addresses 0, D and E. A decoder that looks at too many address bits would lose the first kind of write, and one that aliases the dead addresses would corrupt a digit. Display test and shutdown are each toggled both ways, including test during shutdown, to catch designs that overwrite the stored registers. A chained transfer compares `ser_dout` bit for bit with the previous frame.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
   localparam int FRAME_W    = 16;
   localparam int ADDR_W     = 4;
   localparam int DATA_W     = 8;
   localparam int NUM_DIGITS = 8;
   localparam int DIG_W      = $clog2(NUM_DIGITS);
   localparam int PHASES     = 16;
   localparam int PHASE_W    = $clog2(PHASES);

   localparam logic [ADDR_W-1:0] ADR_DECODE = 4'h9;
   localparam logic [ADDR_W-1:0] ADR_INTENS = 4'hA;
   localparam logic [ADDR_W-1:0] ADR_LIMIT  = 4'hB;
   localparam logic [ADDR_W-1:0] ADR_CONFIG = 4'hC;
   localparam logic [ADDR_W-1:0] ADR_TEST   = 4'hF;

   typedef struct packed {
      logic [NUM_DIGITS-1:0] decode;
      logic [PHASE_W-1:0]    intensity;
      logic [DIG_W-1:0]      limit;
      logic                  run;
      logic                  test;
   } ctrl_t;

   // glyph bits a..g on [6:0], a at bit 6
   function automatic logic [6:0] codeb_glyph(input logic [3:0] code);
      logic [6:0] g;
      case (code)
         4'h0: g = 7'h7E;
         4'h1: g = 7'h30;
         4'h2: g = 7'h6D;
         4'h3: g = 7'h79;
         4'h4: g = 7'h33;
         4'h5: g = 7'h5B;
         4'h6: g = 7'h5F;
         4'h7: g = 7'h70;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h7B;
         4'hA: g = 7'h01;
         4'hB: g = 7'h4F;
         4'hC: g = 7'h37;
         4'hD: g = 7'h0E;
         4'hE: g = 7'h67;
         default: g = 7'h00;
      endcase
      return g;
   endfunction
endpackage

// File: rtl/led_serial_port.sv
module led_serial_port
   import led_scan_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_din,
   input  logic                     ser_clk,
   input  logic                     ser_load,
   output logic                     ser_dout,
   output logic                     frame_vld,
   output logic [ADDR_W+DATA_W-1:0] frame_lo
);
   localparam int LO_W = ADDR_W + DATA_W;

   logic [SYNC_STAGES-1:0] clk_pipe, din_pipe, ld_pipe;
   logic                   clk_prev, ld_prev;
   logic [FRAME_W-1:0]     shreg;
   logic                   shift_now, load_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_pipe <= '0;
         din_pipe <= '0;
         ld_pipe  <= '0;
         clk_prev <= 1'b0;
         ld_prev  <= 1'b0;
      end else begin
         clk_pipe <= {clk_pipe[SYNC_STAGES-2:0], ser_clk};
         din_pipe <= {din_pipe[SYNC_STAGES-2:0], ser_din};
         ld_pipe  <= {ld_pipe[SYNC_STAGES-2:0], ser_load};
         clk_prev <= clk_pipe[SYNC_STAGES-1];
         ld_prev  <= ld_pipe[SYNC_STAGES-1];
      end
   end

   assign shift_now = clk_pipe[SYNC_STAGES-1] & ~clk_prev;
   assign load_now  = ld_pipe[SYNC_STAGES-1] & ~ld_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         frame_vld <= 1'b0;
         frame_lo  <= '0;
      end else begin
         if (shift_now) shreg <= {shreg[FRAME_W-2:0], din_pipe[SYNC_STAGES-1]};
         frame_vld <= load_now;
         if (load_now) frame_lo <= shreg[LO_W-1:0];
      end
   end

   assign ser_dout = shreg[FRAME_W-1];
endmodule

// File: rtl/led_regfile.sv
module led_regfile
   import led_scan_pkg::*;
(
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                frame_vld,
   input  logic [ADDR_W+DATA_W-1:0]            frame_lo,
   output logic [NUM_DIGITS-1:0][DATA_W-1:0]   digit_q,
   output ctrl_t                               ctrl_q
);
   logic [ADDR_W-1:0] adr;
   logic [DATA_W-1:0] dat;

   assign adr = frame_lo[ADDR_W+DATA_W-1:DATA_W];
   assign dat = frame_lo[DATA_W-1:0];

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
      localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(g + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          digit_q[g] <= '0;
         else if (frame_vld && adr == MY_ADR) digit_q[g] <= dat;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (frame_vld) begin
         case (adr)
            ADR_DECODE: ctrl_q.decode    <= dat[NUM_DIGITS-1:0];
            ADR_INTENS: ctrl_q.intensity <= dat[PHASE_W-1:0];
            ADR_LIMIT:  ctrl_q.limit     <= dat[DIG_W-1:0];
            ADR_CONFIG: ctrl_q.run       <= dat[0];
            ADR_TEST:   ctrl_q.test      <= dat[0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
   import led_scan_pkg::*;
#(
   parameter int SUB_CYCLES = 94
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIG_W-1:0]   limit,
   output logic [DIG_W-1:0]   digit_idx,
   output logic [PHASE_W-1:0] phase
);
   localparam int SUB_W = (SUB_CYCLES > 1) ? $clog2(SUB_CYCLES) : 1;
   localparam logic [SUB_W-1:0]   SUB_LAST   = SUB_W'(SUB_CYCLES - 1);
   localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(PHASES - 1);

   logic [SUB_W-1:0] sub_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_cnt   <= '0;
         phase     <= '0;
         digit_idx <= '0;
      end else if (sub_cnt == SUB_LAST) begin
         sub_cnt <= '0;
         phase   <= phase + 1'b1;
         if (phase == PHASE_LAST)
            digit_idx <= (digit_idx >= limit) ? '0 : digit_idx + 1'b1;
      end else begin
         sub_cnt <= sub_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/led_seg_out.sv
module led_seg_out
   import led_scan_pkg::*;
(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_DIGITS-1:0][DATA_W-1:0] digit_q,
   input  ctrl_t                             ctrl_q,
   input  logic [DIG_W-1:0]                  digit_idx,
   input  logic [PHASE_W-1:0]                phase,
   output logic [NUM_DIGITS-1:0]             cath_n,
   output logic [DATA_W-1:0]                 seg
);
   logic [DATA_W-1:0]     cur, pattern, seg_nxt;
   logic [NUM_DIGITS-1:0] cath_nxt;
   logic                  lit;

   assign cur     = digit_q[digit_idx];
   assign pattern = ctrl_q.decode[digit_idx] ? {cur[7], codeb_glyph(cur[3:0])} : cur;
   assign lit     = ctrl_q.run | ctrl_q.test;

   always_comb begin
      if (!lit)                         seg_nxt = '0;
      else if (ctrl_q.test)             seg_nxt = '1;
      else if (phase < ctrl_q.intensity) seg_nxt = pattern;
      else                              seg_nxt = '0;
   end

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cath
      assign cath_nxt[g] = ~(lit && digit_idx == DIG_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cath_n <= '1;
         seg    <= '0;
      end else begin
         cath_n <= cath_nxt;
         seg    <= seg_nxt;
      end
   end
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
   import led_scan_pkg::*;
#(
   parameter int SUB_CYCLES  = 94,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_din,
   input  logic                  ser_clk,
   input  logic                  ser_load,
   output logic                  ser_dout,
   output logic [NUM_DIGITS-1:0] cath_n,
   output logic [DATA_W-1:0]     seg
);
   if (SUB_CYCLES < 1) begin : g_bad_sub
      $error("SUB_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                              frame_vld;
   logic [ADDR_W+DATA_W-1:0]          frame_lo;
   logic [NUM_DIGITS-1:0][DATA_W-1:0] digit_q;
   ctrl_t                             ctrl_q;
   logic [DIG_W-1:0]                  digit_idx;
   logic [PHASE_W-1:0]                phase;
   logic                              run_en, test_en;
   logic [PHASE_W-1:0]                intensity_q;

   assign run_en      = ctrl_q.run;
   assign test_en     = ctrl_q.test;
   assign intensity_q = ctrl_q.intensity;

   led_serial_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
      .ser_load(ser_load), .ser_dout(ser_dout),
      .frame_vld(frame_vld), .frame_lo(frame_lo)
   );

   led_regfile u_regs (
      .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_lo(frame_lo),
      .digit_q(digit_q), .ctrl_q(ctrl_q)
   );

   led_scan_seq #(.SUB_CYCLES(SUB_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .limit(ctrl_q.limit),
      .digit_idx(digit_idx), .phase(phase)
   );

   led_seg_out u_out (
      .clk(clk), .rst_n(rst_n), .digit_q(digit_q), .ctrl_q(ctrl_q),
      .digit_idx(digit_idx), .phase(phase), .cath_n(cath_n), .seg(seg)
   );
endmodule

// File: rtl/led_scan_ctrl_chk.sv
module led_scan_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] cath_n,
   input logic [7:0] seg,
   input logic       run_en,
   input logic       test_en,
   input logic [3:0] intensity_q
);
   // R9
   onehot_cath_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cath_n));

   // R10
   shutdown_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !test_en) |=> (cath_n == 8'hFF && seg == 8'h00));

   // R11
   test_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_en |=> (seg == 8'hFF && cath_n != 8'hFF));

   // R7
   zero_int_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (intensity_q == 4'h0 && !test_en) |=> (seg == 8'h00));

   // R8
   seg_needs_cath_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg != 8'h00) |-> (cath_n != 8'hFF));
endmodule

bind led_scan_ctrl led_scan_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cath_n(cath_n), .seg(seg),
   .run_en(run_en), .test_en(test_en), .intensity_q(intensity_q)
);

// File: tb/led_scan_ctrl_bench.sv
module led_scan_ctrl_bench;
   localparam int SUB  = 4;
   localparam int SLOT = 16 * SUB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_din = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
   logic       ser_dout;
   logic [7:0] cath_n, seg;

   always #2.5 clk = ~clk;

   led_scan_ctrl #(.SUB_CYCLES(SUB), .SYNC_STAGES(2)) u_led_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
      .ser_load(ser_load), .ser_dout(ser_dout), .cath_n(cath_n), .seg(seg)
   );

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   // bench model of the register file
   logic [7:0] md_dig [8];
   logic [7:0] md_dec;
   logic [3:0] md_int;
   logic [2:0] md_lim;
   logic       md_run, md_test;

   int         ms_lit [8];
   int         ms_on  [8];
   logic [7:0] ms_seen [8];
   int         ms_bad;
   logic [15:0] dout_cap;

   task automatic chk(input bit ok, input string req, input string msg);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   function automatic logic [6:0] exp_glyph(input logic [3:0] c);
      case (c)
         4'h0: return 7'b1111110;  4'h1: return 7'b0110000;
         4'h2: return 7'b1101101;  4'h3: return 7'b1111001;
         4'h4: return 7'b0110011;  4'h5: return 7'b1011011;
         4'h6: return 7'b1011111;  4'h7: return 7'b1110000;
         4'h8: return 7'b1111111;  4'h9: return 7'b1111011;
         4'hA: return 7'b0000001;  4'hB: return 7'b1001111;
         4'hC: return 7'b0110111;  4'hD: return 7'b0001110;
         4'hE: return 7'b1100111;  default: return 7'b0000000;
      endcase
   endfunction

   function automatic logic [7:0] exp_pat(input int d);
      if (md_dec[d]) return {md_dig[d][7], exp_glyph(md_dig[d][3:0])};
      return md_dig[d];
   endfunction

   task automatic model_apply(input logic [15:0] f);
      logic [3:0] a = f[11:8];
      if (a >= 4'h1 && a <= 4'h8) md_dig[a-1] = f[7:0];
      else if (a == 4'h9) md_dec  = f[7:0];
      else if (a == 4'hA) md_int  = f[3:0];
      else if (a == 4'hB) md_lim  = f[2:0];
      else if (a == 4'hC) md_run  = f[0];
      else if (a == 4'hF) md_test = f[0];
   endtask

   task automatic shift_frame(input logic [15:0] f);
      for (int i = 15; i >= 0; i--) begin
         @(negedge clk);
         ser_din = f[i];
         repeat (4) @(negedge clk);
         dout_cap[i] = ser_dout;
         ser_clk = 1'b1;
         repeat (4) @(negedge clk);
         ser_clk = 1'b0;
      end
   endtask

   task automatic pulse_load(input logic [15:0] f);
      @(negedge clk);
      ser_load = 1'b1;
      repeat (4) @(negedge clk);
      ser_load = 1'b0;
      repeat (4) @(negedge clk);
      model_apply(f);
   endtask

   task automatic wr(input logic [3:0] upper, input logic [3:0] a, input logic [7:0] d);
      logic [15:0] f = {upper, a, d};
      shift_frame(f);
      pulse_load(f);
   endtask

   task automatic measure();
      int period = (int'(md_lim) + 1) * SLOT;
      repeat (9 * SLOT) @(negedge clk);
      for (int d = 0; d < 8; d++) begin
         ms_lit[d] = 0; ms_on[d] = 0; ms_seen[d] = 8'h00;
      end
      ms_bad = 0;
      for (int c = 0; c < 2 * period; c++) begin
         int low = 0, idx = 0;
         @(negedge clk);
         for (int d = 0; d < 8; d++) if (!cath_n[d]) begin low++; idx = d; end
         if (low > 1) ms_bad++;
         if (low == 0 && seg != 8'h00) ms_bad++;
         if (low == 1) begin
            ms_lit[idx]++;
            if (seg != 8'h00) begin
               ms_on[idx]++;
               if (ms_seen[idx] == 8'h00) ms_seen[idx] = seg;
               else if (seg != ms_seen[idx]) ms_bad++;
            end
         end
      end
   endtask

   task automatic check_display(input string req);
      bit lit_on = md_run || md_test;
      measure();
      for (int d = 0; d < 8; d++) begin
         int         e_lit = (lit_on && d <= int'(md_lim)) ? 2 * SLOT : 0;
         logic [7:0] e_pat = md_test ? 8'hFF : exp_pat(d);
         int         e_on;
         if (e_lit == 0 || e_pat == 8'h00) e_on = 0;
         else if (md_test) e_on = e_lit;
         else e_on = 2 * int'(md_int) * SUB;
         if (e_on == 0) e_pat = 8'h00;
         chk(ms_lit[d] == e_lit && ms_on[d] == e_on && ms_seen[d] == e_pat, req,
             $sformatf("digit %0d lit/on/pat got %0d/%0d/%02h exp %0d/%0d/%02h",
                       d, ms_lit[d], ms_on[d], ms_seen[d], e_lit, e_on, e_pat));
      end
      chk(ms_bad == 0, "R9", $sformatf("%s: bad scan cycles got %0d exp 0", req, ms_bad));
   endtask

   initial begin
      for (int d = 0; d < 8; d++) md_dig[d] = 8'h00;
      md_dec = 0; md_int = 0; md_lim = 0; md_run = 0; md_test = 0;
      repeat (5) @(negedge clk);
      // R12 reset outputs
      chk(cath_n == 8'hFF && seg == 8'h00 && ser_dout == 1'b0, "R12",
          $sformatf("reset outputs got %02h/%02h/%b exp FF/00/0", cath_n, seg, ser_dout));
      rst_n = 1'b1;
      check_display("R12");

      // R5 R8 raw patterns, full scan
      wr(4'h0, 4'hB, 8'h07);
      wr(4'h0, 4'hA, 8'h0F);
      for (int d = 0; d < 8; d++) wr(4'h0, 4'(d + 1), 8'(8'h11 * (d + 1)) ^ 8'h80);
      check_display("R10");
      wr(4'h0, 4'hC, 8'h01);
      check_display("R5");

      // R7 intensity sweep
      for (int i = 0; i < 16; i++) begin
         wr(4'h0, 4'hA, 8'(i));
         check_display("R7");
      end

      // R8 scan limit sweep
      wr(4'h0, 4'hA, 8'h08);
      for (int n = 0; n < 8; n++) begin
         wr(4'h0, 4'hB, 8'(n));
         check_display("R8");
      end

      // R4 R6 all font codes, dp on odd digits
      wr(4'h0, 4'h9, 8'hFF);
      for (int r = 0; r < 2; r++) begin
         for (int d = 0; d < 8; d++)
            wr(4'h0, 4'(d + 1), {d[0], 3'b101, 4'(r * 8 + d)});
         check_display("R4");
      end
      // R3 per-digit decode mask
      wr(4'h0, 4'h9, 8'h55);
      check_display("R6");

      // R1 upper nibble ignored
      wr(4'hA, 4'h1, 8'h3C);
      check_display("R1");
      // R3 dead addresses leave everything unchanged
      wr(4'h0, 4'h0, 8'hFF);
      wr(4'h0, 4'hD, 8'hFF);
      wr(4'h0, 4'hE, 8'h00);
      check_display("R3");

      // R11 display test and restore
      wr(4'h0, 4'hA, 8'h01);
      wr(4'h0, 4'hF, 8'h01);
      check_display("R11");
      wr(4'h0, 4'hF, 8'h00);
      check_display("R11");

      // R10 shutdown, test during shutdown, restore
      wr(4'h0, 4'hC, 8'h00);
      check_display("R10");
      wr(4'h0, 4'hF, 8'h01);
      check_display("R11");
      wr(4'h0, 4'hF, 8'h00);
      wr(4'h0, 4'hC, 8'h01);
      check_display("R10");

      // R2 chained transfer: dout replays the previous frame
      shift_frame(16'h5B37);
      shift_frame(16'h0342);
      chk(dout_cap == 16'h5B37, "R2",
          $sformatf("ser_dout stream got %04h exp 5B37", dout_cap));
      pulse_load(16'h0342);
      check_display("R2");

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 190000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: run did not complete, got hang exp finish");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule